// File: doc/BRIEF.md
# Dual-Edge Stuck-At Testable Conservative Flip-Flop

This block stores a data word and updates it on both clock edges. Each data bit has two level-sensitive storage cells built from Fredkin (controlled-swap) gates, and both cells read the same D input. One cell is open while the clock is high. The other is open while the clock is low. A third Fredkin gate per bit, steered by the clock, routes the closed cell to the output. The output therefore changes only at clock edges, and a clock at half the rate of a single-edge register carries the same data rate.

Each cell has two control lines on its feedback path: pc1/pc2 for the high-open cells and nc1/nc2 for the low-open cells. With the normal control pattern the feedback keeps the stored value. With both lines of a cell at the same value the feedback is cut and forced to that value. Every gate is conservative: it preserves the number of ones between its inputs and its outputs. An all-ones stimulus therefore drives every net to 1, and an all-zeros stimulus drives every net to 0.

A detector compares every net of the cells and of the output gate with the applied constant and raises a fault flag on any mismatch. A decoder flags control patterns outside the three legal ones. An active-low reset acts at clock edges: while it is low, the cells load zero.

Top module: `dual_edge_rev_ff`

## Requirements
- R1: With controls {pc1,pc2,nc1,nc2} = 0,1,0,1 (run mode) and rst_n high, after each rising clock edge q equals the d value present just before that edge.
- R2: In run mode, after each falling clock edge q equals the d value present just before that edge.
- R3: In run mode, a change of d while the clock stays at one level leaves q unchanged.
- R4: mode_error is 0 for the control patterns 0101, 1111 and 0000, and 1 for each of the other 13 patterns.
- R5: With all four controls at 1 (stuck-at-0 test) and the clock held high, fault_flag is 0 when every bit of d is 1 and 1 when any bit of d is 0.
- R6: With all four controls at 0 (stuck-at-1 test) and the clock held low, fault_flag is 0 when d is all zeros and 1 when any bit of d is 1.
- R7: In either test mode, a clock level that differs from the test constant raises fault_flag even when d matches the constant.
- R8: fault_flag is 0 in run mode and for every illegal control pattern.
- R9: In a test mode with the matching vector applied, every bit of q equals the test constant.
- R10: While rst_n is low, each clock edge loads zero, so q is 0 after the edge. After rst_n goes high, the next edge captures d again.
- R11: In run mode, the output gate's garbage field garbage[WIDTH-1:0] equals d at both clock levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges capture data |
| rst_n | input | 1 | Active-low reset, acts at clock edges |
| d | input | WIDTH | Data in |
| pc1 | input | 1 | Feedback control 1 of the high-open cells |
| pc2 | input | 1 | Feedback control 2 of the high-open cells |
| nc1 | input | 1 | Feedback control 1 of the low-open cells |
| nc2 | input | 1 | Feedback control 2 of the low-open cells |
| q | output | WIDTH | Data out |
| garbage | output | 5*WIDTH | Unused gate outputs, field k at bits k*WIDTH+i: 0 output-gate swap, 1 high cell swap, 2 high cell inverted feedback, 3 low cell swap, 4 low cell inverted feedback |
| fault_flag | output | 1 | A net differs from the test constant in a legal test mode |
| mode_error | output | 1 | Control pattern is not one of the three legal ones |

## Verification
Every pair of 4-bit words is applied, one word before a rising edge and the next before a falling edge. This separates a correct capture from a swapped latch pair, from an output taken from the open cell, and from a capture on one edge only. After each edge, d is changed to its complement mid-phase to catch a transparent output. In both test modes every d value is tried with the matching clock level: the only vector that gives no fault is the all-equal one, and each single wrong bit must be flagged. The wrong clock level is also tried, and all sixteen control patterns are decoded.

// File: rtl/dual_edge_rev_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the dual-edge testable flip-flop.
// Assumes: nothing; pure declarations.
package dual_edge_rev_pkg;
    typedef enum logic [1:0] {
        MODE_RUN = 2'd0,
        MODE_SA0 = 2'd1,
        MODE_SA1 = 2'd2,
        MODE_BAD = 2'd3
    } ff_mode_e;

    localparam int GARB_FIELDS  = 5;
    localparam int CELL_NETS    = 11;
    localparam int MUX_NETS     = 5;
endpackage

// File: rtl/fredkin_cell.sv
`timescale 1ns/1ps
// Module: fredkin_cell
// A 3x3 controlled-swap gate: p copies a, and when a is 1 the b and c
// lines swap places. The gate conserves the number of ones.
// Assumes: single-bit lines; purely combinational.
module fredkin_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    // Route the two data lines according to the control line.
    always_comb begin
        p = a;
        q = a ? c : b;
        r = a ? b : c;
    end
endmodule

// File: rtl/ctrl_decode.sv
`timescale 1ns/1ps
// Module: ctrl_decode
// Turns the four feedback control lines into an operating mode, a run
// enable, a test enable, the test constant and an illegal-pattern flag.
// Assumes: controls are quasi-static relative to the clock.
module ctrl_decode
    import dual_edge_rev_pkg::*;
(
    input  logic     pc1,
    input  logic     pc2,
    input  logic     nc1,
    input  logic     nc2,
    output ff_mode_e mode,
    output logic     run_en,
    output logic     test_en,
    output logic     test_val,
    output logic     mode_error
);
    // Classify the control pattern into one of the legal modes.
    always_comb begin
        unique case ({pc1, pc2, nc1, nc2})
            4'b0101: mode = MODE_RUN;
            4'b1111: mode = MODE_SA0;
            4'b0000: mode = MODE_SA1;
            default: mode = MODE_BAD;
        endcase
    end

    // Derive the enables and the constant the detectors compare against.
    always_comb begin
        run_en     = (mode == MODE_RUN);
        test_en    = (mode == MODE_SA0) || (mode == MODE_SA1);
        test_val   = (mode == MODE_SA0);
        mode_error = (mode == MODE_BAD);
    end
endmodule

// File: rtl/rev_latch.sv
`timescale 1ns/1ps
// Module: rev_latch
// One-bit level-sensitive cell made of two Fredkin gates. The first gate
// chooses between d and the feedback line, steered by the clock. The
// second gate copies the stored value onto the feedback line through the
// c1/c2 controls. With c1=0, c2=1 the feedback holds the state. With
// c1==c2 the feedback is cut and forced to that constant. A detector flags
// any net that differs from the test constant while testing.
// Assumes: OPEN_HIGH=1 makes the cell transparent while clk is high,
// OPEN_HIGH=0 while clk is low.
module rev_latch #(
    parameter bit OPEN_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic c1,
    input  logic c2,
    input  logic run_en,
    input  logic test_en,
    input  logic test_val,
    output logic y,
    output logic g_swap,
    output logic g_inv,
    output logic fault
);
    import dual_edge_rev_pkg::*;

    logic open_en;
    logic fb_cut;
    logic st;
    logic st_copy;
    logic fb;
    logic fb_bar;
    logic clk_copy;
    logic [CELL_NETS-1:0] nets;

    // Transparency follows the clock level chosen by the parameter.
    always_comb begin
        open_en = OPEN_HIGH ? clk : ~clk;
        fb_cut  = (c1 == c2);
    end

    // Storage node: follows d while open; takes the forced constant when
    // the feedback is cut; otherwise keeps its value.
    always_latch begin
        if (open_en || fb_cut) begin
            st <= open_en ? d : c1;
        end
    end

    // Feedback copy gate: stored value steers the two control lines.
    fredkin_cell u_fb (
        .a (st),
        .b (c1),
        .c (c2),
        .p (st_copy),
        .q (fb),
        .r (fb_bar)
    );

    // Data-select gate; input order picks the open clock level.
    generate
        if (OPEN_HIGH) begin : g_high
            fredkin_cell u_sel (
                .a (clk),
                .b (fb),
                .c (d),
                .p (clk_copy),
                .q (y),
                .r (g_swap)
            );
        end else begin : g_low
            fredkin_cell u_sel (
                .a (clk),
                .b (d),
                .c (fb),
                .p (clk_copy),
                .q (y),
                .r (g_swap)
            );
        end
    endgenerate

    // Gather every net of both gates for the stuck-at comparison.
    always_comb begin
        nets  = {clk, d, c1, c2, st, st_copy, fb, fb_bar, clk_copy, y, g_swap};
        g_inv = fb_bar;
        fault = test_en && (|(nets ^ {CELL_NETS{test_val}}));
    end

    // The open cell passes d just before the edge that closes it.
    generate
        if (OPEN_HIGH) begin : g_chk_high
            p_open_pass_r2: assert property (@(negedge clk) disable iff (!rst_n)
                run_en |-> (y == d));
        end else begin : g_chk_low
            p_open_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
                run_en |-> (y == d));
        end
    endgenerate
endmodule

// File: rtl/dual_edge_rev_ff.sv
`timescale 1ns/1ps
// Module: dual_edge_rev_ff
// Dual-edge register: per bit, a high-open and a low-open reversible cell
// share d. A clock-steered Fredkin gate routes the closed cell to q, so q
// updates on both edges. Fault detectors of all gates are ORed into
// fault_flag. Reset gates d to zero, so its effect lands at clock edges.
// Assumes: rst_n is high during test modes; controls change only while
// the clock is static.
module dual_edge_rev_ff
    import dual_edge_rev_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WIDTH-1:0]             d,
    input  logic                         pc1,
    input  logic                         pc2,
    input  logic                         nc1,
    input  logic                         nc2,
    output logic [WIDTH-1:0]             q,
    output logic [GARB_FIELDS*WIDTH-1:0] garbage,
    output logic                         fault_flag,
    output logic                         mode_error
);
    localparam int GW = GARB_FIELDS * WIDTH;

    ff_mode_e         mode;
    logic             run_en;
    logic             test_en;
    logic             test_val;
    logic [WIDTH-1:0] d_in;
    logic [WIDTH-1:0] y_hi;
    logic [WIDTH-1:0] y_lo;
    logic [WIDTH-1:0] hi_swap;
    logic [WIDTH-1:0] hi_inv;
    logic [WIDTH-1:0] lo_swap;
    logic [WIDTH-1:0] lo_inv;
    logic [WIDTH-1:0] mux_swap;
    logic [WIDTH-1:0] mux_clk;
    logic [WIDTH-1:0] hi_fault;
    logic [WIDTH-1:0] lo_fault;
    logic [WIDTH-1:0] mux_fault;
    logic [GW-1:0]    garb_int;

    // Decode the control lines once for all bits.
    ctrl_decode u_dec (
        .pc1        (pc1),
        .pc2        (pc2),
        .nc1        (nc1),
        .nc2        (nc2),
        .mode       (mode),
        .run_en     (run_en),
        .test_en    (test_en),
        .test_val   (test_val),
        .mode_error (mode_error)
    );

    // Reset forces zero into whichever cell is open at the next edge.
    always_comb begin
        d_in = rst_n ? d : '0;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            rev_latch #(.OPEN_HIGH(1'b1)) u_hi (
                .clk      (clk),
                .rst_n    (rst_n),
                .d        (d_in[i]),
                .c1       (pc1),
                .c2       (pc2),
                .run_en   (run_en),
                .test_en  (test_en),
                .test_val (test_val),
                .y        (y_hi[i]),
                .g_swap   (hi_swap[i]),
                .g_inv    (hi_inv[i]),
                .fault    (hi_fault[i])
            );

            rev_latch #(.OPEN_HIGH(1'b0)) u_lo (
                .clk      (clk),
                .rst_n    (rst_n),
                .d        (d_in[i]),
                .c1       (nc1),
                .c2       (nc2),
                .run_en   (run_en),
                .test_en  (test_en),
                .test_val (test_val),
                .y        (y_lo[i]),
                .g_swap   (lo_swap[i]),
                .g_inv    (lo_inv[i]),
                .fault    (lo_fault[i])
            );

            // Clock high shows the low-open (closed) cell, clock low the high-open one.
            fredkin_cell u_mux (
                .a (clk),
                .b (y_hi[i]),
                .c (y_lo[i]),
                .p (mux_clk[i]),
                .q (q[i]),
                .r (mux_swap[i])
            );

            // Compare the output gate's nets with the test constant.
            always_comb begin
                mux_fault[i] = test_en &&
                    (|({mux_clk[i], y_hi[i], y_lo[i], q[i], mux_swap[i]}
                       ^ {MUX_NETS{test_val}}));
            end

            // Just before a rising edge the output shows the high-open cell.
            p_out_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
                run_en |-> (q[i] == y_hi[i]));

            // Just before a falling edge the output shows the low-open cell.
            p_out_side_r2: assert property (@(negedge clk) disable iff (!rst_n)
                run_en |-> (q[i] == y_lo[i]));
        end
    endgenerate

    // Pack the unused gate outputs into their fields.
    always_comb begin
        garb_int = {lo_inv, lo_swap, hi_inv, hi_swap, mux_swap};
        garbage  = garb_int;
    end

    // Combine every detector into a single flag.
    always_comb begin
        fault_flag = (|hi_fault) || (|lo_fault) || (|mux_fault);
    end

    // An illegal control pattern never reports a fault.
    p_bad_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_error |-> !fault_flag);

    // Run mode never reports a fault.
    p_run_quiet_r8: assert property (@(negedge clk) disable iff (!rst_n)
        run_en |-> !fault_flag);
endmodule

// File: tb/dual_edge_rev_ff_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive word-pair sweep on both edges, a full control decode
// sweep and both test modes over every d value.
module dual_edge_rev_ff_tb;
    localparam int W = 4;

    logic           clk;
    logic           rst_n;
    logic [W-1:0]   d;
    logic           pc1, pc2, nc1, nc2;
    logic [W-1:0]   q;
    logic [5*W-1:0] garbage;
    logic           fault_flag;
    logic           mode_error;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    dual_edge_rev_ff #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .d          (d),
        .pc1        (pc1),
        .pc2        (pc2),
        .nc1        (nc1),
        .nc2        (nc2),
        .q          (q),
        .garbage    (garbage),
        .fault_flag (fault_flag),
        .mode_error (mode_error)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive d, wait half a phase, toggle the clock (20 ns period), settle.
    task automatic phase(input logic [W-1:0] dv);
        d = dv;
        #5;
        clk = ~clk;
        #5;
    endtask

    task automatic set_ctrl(input logic [3:0] m);
        {pc1, pc2, nc1, nc2} = m;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        clk = 1'b0;
        rst_n = 1'b0;
        d = '0;
        set_ctrl(4'b0101);
        // R10: reset state after two edges.
        phase(4'hF);
        phase(4'hF);
        chk(q == 0, "R10 reset state", q, 0);
        chk(fault_flag == 0 && mode_error == 0, "R8 reset flags", {fault_flag, mode_error}, 0);
        rst_n = 1'b1;

        // R1/R2/R3/R11: every pair of words over both edges.
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = v[3:0];
            b = v[7:4];
            phase(a);
            chk(q == a, "R1 rising capture", q, a);
            chk(garbage[W-1:0] == a, "R11 garbage follows d", garbage[W-1:0], a);
            d = ~a;
            #1;
            chk(q == a, "R3 hold while high", q, a);
            chk(garbage[W-1:0] == ~a, "R11 garbage follows d high", garbage[W-1:0], 4'(~a));
            phase(b);
            chk(q == b, "R2 falling capture", q, b);
            d = ~b;
            #1;
            chk(q == b, "R3 hold while low", q, b);
            chk(garbage[W-1:0] == ~b, "R11 garbage follows d low", garbage[W-1:0], 4'(~b));
        end

        // R10: mid-run reset and release.
        rst_n = 1'b0;
        phase(4'hA);
        chk(q == 0, "R10 reset loads zero", q, 0);
        rst_n = 1'b1;
        phase(4'h5);
        chk(q == 4'h5, "R10 capture after release", q, 5);
        phase(4'h3);
        chk(q == 4'h3, "R10 second edge after release", q, 3);

        // R4/R8: decode of every control pattern with the clock static.
        for (int m = 0; m < 16; m++) begin
            bit legal;
            legal = (m == 5) || (m == 15) || (m == 0);
            set_ctrl(m[3:0]);
            d = 4'h6;
            #5;
            chk(mode_error == !legal, "R4 mode decode", mode_error, !legal);
            if (!legal || m == 5)
                chk(fault_flag == 0, "R8 no fault outside test", fault_flag, 0);
        end

        // R5/R9: stuck-at-0 test, all controls 1, clock high.
        set_ctrl(4'b1111);
        clk = 1'b1;
        for (int v = 0; v < 16; v++) begin
            d = v[3:0];
            #5;
            chk(fault_flag == (v != 15), "R5 all-ones vector", fault_flag, v != 15);
            if (v == 15) chk(q == 4'hF, "R9 q at ones constant", q, 15);
        end
        // R7: wrong clock level in the stuck-at-0 test.
        clk = 1'b0;
        d = 4'hF;
        #5;
        chk(fault_flag == 1, "R7 clock low in ones test", fault_flag, 1);

        // R6/R9: stuck-at-1 test, all controls 0, clock low.
        set_ctrl(4'b0000);
        for (int v = 0; v < 16; v++) begin
            d = v[3:0];
            #5;
            chk(fault_flag == (v != 0), "R6 all-zeros vector", fault_flag, v != 0);
            if (v == 0) chk(q == 4'h0, "R9 q at zeros constant", q, 0);
        end
        // R7: wrong clock level in the stuck-at-1 test.
        clk = 1'b1;
        d = 4'h0;
        #5;
        chk(fault_flag == 1, "R7 clock high in zeros test", fault_flag, 1);

        // Back to run mode: capture resumes on the next edges.
        set_ctrl(4'b0101);
        #5;
        phase(4'h9);
        chk(q == 4'h9, "R2 capture after test mode", q, 9);
        phase(4'hC);
        chk(q == 4'hC, "R1 capture after test mode", q, 12);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule